// File: doc/BRIEF.md
# Address-Space and Byte-Order Unit for Load/Store Accesses

This block sits between the integer pipeline and a 64-bit data memory port. For every access it chooses the address space identifier (ASI) and decides whether the access is little-endian. It byte-swaps store data on the way out and returned load data on the way back. It also flags a privileged-action fault when nonprivileged code names a restricted address space. The implicit ASI of an ordinary data access depends on two things: whether the processor is at trap level zero, and the current-endian mode bit. Alternate-space accesses take their ASI from the instruction's immediate field or from the ASI register, chosen by the instruction's i bit.

The selection and swapping logic is combinational. A single register stage follows it, so every result appears on the outputs one clock after the access is presented. Single-register accesses are swapped across their whole size and kept right-aligned in the 64-bit lane. A doubleword register-pair access in little-endian mode is handled as two independent 32-bit words, and each word is swapped on its own.

Top module: `asi_endian_unit`

## Requirements
- R1: For an alternate-space access (kind 2) or a prefetch-alternate access (kind 3) with `acc_imm_sel`=0, `out_asi` equals `acc_imm_asi`.
- R2: For an alternate-space or prefetch-alternate access with `acc_imm_sel`=1, `out_asi` equals `asi_reg`.
- R3: An instruction fetch (kind 0) gets ASI 0x80 when `trap_lvl`=0 and 0x04 otherwise. It is always big-endian (`out_little`=0), whatever the value of `cur_le`.
- R4: A normal data access (kind 1) gets ASI 0x80 (trap_lvl=0, cur_le=0), 0x88 (trap_lvl=0, cur_le=1), 0x04 (trap_lvl>0, cur_le=0) or 0x0C (trap_lvl>0, cur_le=1).
- R5: For kinds 1 to 3, `out_little` equals bit 3 of the chosen ASI.
- R6: A little-endian single-register access reverses the byte order of the low 1, 2, 4 or 8 bytes, for size codes 0, 1, 2 and 3 respectively. This applies to both store and load data. All bytes above the access size read as zero.
- R7: A big-endian single-register access passes the low bytes of the access size through unchanged and zeroes all bytes above them.
- R8: When `acc_pair`=1 and the access is little-endian, bytes 3..0 and bytes 7..4 are each reversed within their own 32-bit word, on both store and load data. When `acc_pair`=1 and the access is big-endian, all 64 bits pass through unchanged. The size code is ignored whenever `acc_pair`=1.
- R9: A valid alternate-space access (kind 2) made with `priv_mode`=0 and a chosen ASI below 0x80 raises `out_priv_fault`.
- R10: No fault is raised for kinds 0 and 1, when `priv_mode`=1, or when the chosen ASI is 0x80 or above.
- R11: A nonprivileged prefetch-alternate access with a restricted ASI raises `out_priv_fault` only when the parameter `PF_FAULT` is 1. When `PF_FAULT` is 0 it completes as a no-op, with no fault.
- R12: All outputs are registered and show the access presented one clock earlier. While `rst_n` is low at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 fetch, 1 data, 2 alternate-space, 3 prefetch-alternate |
| acc_imm_sel | input | 1 | Instruction i bit: 0 uses the immediate ASI, 1 uses the ASI register |
| acc_imm_asi | input | 8 | Immediate ASI field of the instruction |
| asi_reg | input | 8 | Current ASI register value |
| trap_lvl | input | TL_W | Current trap level |
| cur_le | input | 1 | Current-endian mode bit |
| priv_mode | input | 1 | Privileged mode |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| acc_pair | input | 1 | Register-pair doubleword access |
| st_data | input | 64 | Store data from the registers |
| ld_raw | input | 64 | Load data returned from memory |
| out_valid | output | 1 | Registered access valid |
| out_asi | output | 8 | Chosen ASI |
| out_little | output | 1 | Access is little-endian |
| out_st_data | output | 64 | Store data in memory byte order |
| out_ld_data | output | 64 | Load data in register byte order |
| out_priv_fault | output | 1 | Privileged-action fault |

## Verification
The outputs are registered, so a wrong choice of ASI, a wrong endian decision or a wrong swap pattern shows up on the ports exactly one clock after the access that caused it. A selection error shows in `out_asi` and `out_little` together. A swap error shows as misplaced or non-zero upper bytes in the two data outputs. Because each cycle is independent, the bench compares every field of every access against its model on the very next negative edge, so a fault is tied to the stimulus that caused it.

// File: rtl/asi_unit_pkg.sv
// Shared constants and types for the address-space and byte-order unit.
// Assumes 8-bit ASIs; bit 3 of an ASI marks little-endian order.
package asi_unit_pkg;

    localparam int          ASI_W        = 8;
    localparam logic [7:0]  ASI_PRI      = 8'h80;
    localparam logic [7:0]  ASI_PRI_LE   = 8'h88;
    localparam logic [7:0]  ASI_NUC      = 8'h04;
    localparam logic [7:0]  ASI_NUC_LE   = 8'h0C;
    localparam int          LE_BIT       = 3;
    localparam logic [7:0]  OPEN_ASI_MIN = 8'h80;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_DATA   = 2'd1,
        ACC_ALT    = 2'd2,
        ACC_PF_ALT = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [ASI_W-1:0] asi;
        logic             little;
        logic             fault;
    } asi_sel_t;

endpackage

// File: rtl/asi_select.sv
// ASI selection and privilege check.
// Picks the implicit ASI from trap level and endian mode, or the explicit
// ASI from the immediate field or ASI register; flags restricted ASIs
// used from nonprivileged mode. Purely combinational.
module asi_select
    import asi_unit_pkg::*;
#(
    parameter int TL_W     = 3,
    parameter bit PF_FAULT = 1'b1
) (
    input  logic             valid,
    input  acc_kind_e        kind,
    input  logic             imm_sel,
    input  logic [ASI_W-1:0] imm_asi,
    input  logic [ASI_W-1:0] asi_reg,
    input  logic [TL_W-1:0]  trap_lvl,
    input  logic             cur_le,
    input  logic             priv_mode,
    output asi_sel_t         sel
);

    logic at_tl0;
    logic restricted;
    logic fault_kind;

    // Trap level zero selects the primary space, otherwise the nucleus space.
    assign at_tl0 = (trap_lvl == '0);

    // Choose the ASI for this access kind.
    always_comb begin
        unique case (kind)
            ACC_FETCH: sel.asi = at_tl0 ? ASI_PRI : ASI_NUC;
            ACC_DATA:  sel.asi = at_tl0 ? (cur_le ? ASI_PRI_LE : ASI_PRI)
                                        : (cur_le ? ASI_NUC_LE : ASI_NUC);
            default:   sel.asi = imm_sel ? asi_reg : imm_asi;
        endcase
    end

    // Fetches are always big-endian; other kinds follow the ASI's endian bit.
    assign sel.little = (kind != ACC_FETCH) && sel.asi[LE_BIT];

    // Explicit-ASI kinds that may fault; prefetch only when configured so.
    assign fault_kind = (kind == ACC_ALT) || ((kind == ACC_PF_ALT) && PF_FAULT);

    // Restricted ASIs lie below the open range.
    assign restricted = (sel.asi < OPEN_ASI_MIN);

    // Privileged-action fault for nonprivileged use of a restricted ASI.
    assign sel.fault = valid && fault_kind && restricted && !priv_mode;

endmodule

// File: rtl/lane_swap.sv
// Byte-order converter for one 64-bit data lane.
// Single accesses are reversed over their size and right-aligned with the
// upper bytes zeroed; pair accesses reverse each half-lane word on its own.
// Assumes the lane is a power-of-two number of bytes. Combinational.
module lane_swap #(
    parameter  int DATA_W = 64,
    localparam int NB     = DATA_W / 8,
    localparam int NSZ    = $clog2(NB) + 1,
    localparam int SIZE_W = $clog2(NSZ)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SIZE_W-1:0] size,
    input  logic              pair,
    input  logic              little,
    output logic [DATA_W-1:0] dout
);

    localparam int HB = NB / 2;

    logic [NB-1:0][7:0] bi;
    logic [NB-1:0][7:0] bo;

    assign bi   = din;
    assign dout = bo;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam int PSRC = (b / HB) * HB + (HB - 1) - (b % HB);
        logic [NSZ-1:0][7:0] cand;
        logic [7:0]          res;

        for (genvar s = 0; s < NSZ; s++) begin : g_sz
            localparam int SN = 1 << s;
            if (b < SN) begin : g_in
                // Byte lies inside an access of this size.
                assign cand[s] = little ? bi[SN-1-b] : bi[b];
            end else begin : g_out
                // Byte lies above an access of this size.
                assign cand[s] = '0;
            end
        end

        // Pair accesses swap within the half-lane word; singles use the size.
        always_comb begin
            if (pair) res = little ? bi[PSRC] : bi[b];
            else      res = cand[size];
        end

        assign bo[b] = res;
    end

endmodule

// File: rtl/asi_endian_unit.sv
// Top of the address-space and byte-order unit.
// Combines ASI selection with store and load lane swapping, then registers
// every result for one cycle. Assumes alignment and translation are handled
// elsewhere. Synchronous active-low reset clears all outputs.
module asi_endian_unit
    import asi_unit_pkg::*;
#(
    parameter  int TL_W     = 3,
    parameter  bit PF_FAULT = 1'b1,
    parameter  int DATA_W   = 64,
    localparam int NB       = DATA_W / 8,
    localparam int SIZE_W   = $clog2($clog2(NB) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic              acc_imm_sel,
    input  logic [7:0]        acc_imm_asi,
    input  logic [7:0]        asi_reg,
    input  logic [TL_W-1:0]   trap_lvl,
    input  logic              cur_le,
    input  logic              priv_mode,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic              acc_pair,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] ld_raw,
    output logic              out_valid,
    output logic [7:0]        out_asi,
    output logic              out_little,
    output logic [DATA_W-1:0] out_st_data,
    output logic [DATA_W-1:0] out_ld_data,
    output logic              out_priv_fault
);

    acc_kind_e         kind_e;
    asi_sel_t          sel;
    logic [DATA_W-1:0] st_sw;
    logic [DATA_W-1:0] ld_sw;

    assign kind_e = acc_kind_e'(acc_kind);

    asi_select #(
        .TL_W     (TL_W),
        .PF_FAULT (PF_FAULT)
    ) u_select (
        .valid     (acc_valid),
        .kind      (kind_e),
        .imm_sel   (acc_imm_sel),
        .imm_asi   (acc_imm_asi),
        .asi_reg   (asi_reg),
        .trap_lvl  (trap_lvl),
        .cur_le    (cur_le),
        .priv_mode (priv_mode),
        .sel       (sel)
    );

    lane_swap #(.DATA_W(DATA_W)) u_st_swap (
        .din    (st_data),
        .size   (acc_size),
        .pair   (acc_pair),
        .little (sel.little),
        .dout   (st_sw)
    );

    lane_swap #(.DATA_W(DATA_W)) u_ld_swap (
        .din    (ld_raw),
        .size   (acc_size),
        .pair   (acc_pair),
        .little (sel.little),
        .dout   (ld_sw)
    );

    // Output register stage: one cycle from access to result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_asi        <= '0;
            out_little     <= 1'b0;
            out_st_data    <= '0;
            out_ld_data    <= '0;
            out_priv_fault <= 1'b0;
        end else begin
            out_valid      <= acc_valid;
            out_asi        <= sel.asi;
            out_little     <= sel.little;
            out_st_data    <= st_sw;
            out_ld_data    <= ld_sw;
            out_priv_fault <= sel.fault;
        end
    end

    // Fetch results are never little-endian.
    assert_fetch_big_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(acc_kind) == ACC_FETCH)) |-> !out_little);

    // Fetch ASI is one of the two implicit big-endian spaces.
    assert_fetch_asi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(acc_kind) == ACC_FETCH))
            |-> (out_asi == ASI_PRI || out_asi == ASI_NUC));

    // Byte-sized single accesses leave the upper bytes at zero.
    assert_byte_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(acc_size == '0 && !acc_pair))
            |-> (out_st_data[DATA_W-1:8] == '0 && out_ld_data[DATA_W-1:8] == '0));

    // Privileged mode never faults.
    assert_priv_no_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(priv_mode) |-> !out_priv_fault);

    // A fault only follows a valid explicit-ASI access below the open range.
    assert_fault_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_priv_fault |-> ($past(acc_valid) && $past(acc_kind[1]) && (out_asi < OPEN_ASI_MIN)));

endmodule

// File: tb/test_asi_endian_unit.sv
`timescale 1ns/1ps
module test_asi_endian_unit;

    localparam int  TL_W     = 3;
    localparam bit  PF_FAULT = 1'b1;
    localparam real HALF_NS  = 10.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        acc_imm_sel = 1'b0;
    logic [7:0]  acc_imm_asi = '0;
    logic [7:0]  asi_reg = '0;
    logic [2:0]  trap_lvl = '0;
    logic        cur_le = 1'b0;
    logic        priv_mode = 1'b0;
    logic [1:0]  acc_size = '0;
    logic        acc_pair = 1'b0;
    logic [63:0] st_data = '0;
    logic [63:0] ld_raw = '0;
    logic        out_valid;
    logic [7:0]  out_asi;
    logic        out_little;
    logic [63:0] out_st_data;
    logic [63:0] out_ld_data;
    logic        out_priv_fault;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(HALF_NS) clk = ~clk;

    asi_endian_unit #(.TL_W(TL_W), .PF_FAULT(PF_FAULT)) i_asi_endian_unit (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_imm_sel(acc_imm_sel), .acc_imm_asi(acc_imm_asi), .asi_reg(asi_reg),
        .trap_lvl(trap_lvl), .cur_le(cur_le), .priv_mode(priv_mode),
        .acc_size(acc_size), .acc_pair(acc_pair), .st_data(st_data), .ld_raw(ld_raw),
        .out_valid(out_valid), .out_asi(out_asi), .out_little(out_little),
        .out_st_data(out_st_data), .out_ld_data(out_ld_data),
        .out_priv_fault(out_priv_fault)
    );

    // Compare one value and report a mismatch.
    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference byte-order model, written byte by byte.
    function automatic logic [63:0] model_swap(input logic [63:0] d, input int sz,
                                               input bit pair, input bit le);
        logic [63:0] r = '0;
        if (pair) begin
            for (int k = 0; k < 8; k++) begin
                int src = le ? ((k / 4) * 4 + 3 - (k % 4)) : k;
                r[8*k +: 8] = d[8*src +: 8];
            end
        end else begin
            int n = 1 << sz;
            for (int k = 0; k < n; k++) begin
                int src = le ? (n - 1 - k) : k;
                r[8*k +: 8] = d[8*src +: 8];
            end
        end
        return r;
    endfunction

    // Present one access, then check every output one clock later.
    task automatic do_acc(input int kind, input bit isel, input logic [7:0] imm,
                          input logic [7:0] areg, input int tl, input bit le,
                          input bit priv, input int sz, input bit pair,
                          input logic [63:0] sd, input logic [63:0] ld);
        logic [7:0] e_asi;
        bit e_le, e_fault;
        string r_asi, r_dat, r_flt;
        acc_valid = 1'b1; acc_kind = 2'(kind); acc_imm_sel = isel;
        acc_imm_asi = imm; asi_reg = areg; trap_lvl = 3'(tl); cur_le = le;
        priv_mode = priv; acc_size = 2'(sz); acc_pair = pair;
        st_data = sd; ld_raw = ld;
        if (kind == 0) begin
            e_asi = (tl == 0) ? 8'h80 : 8'h04; r_asi = "R3";
        end else if (kind == 1) begin
            if (tl == 0) e_asi = le ? 8'h88 : 8'h80;
            else         e_asi = le ? 8'h0C : 8'h04;
            r_asi = "R4";
        end else begin
            e_asi = isel ? areg : imm; r_asi = isel ? "R2" : "R1";
        end
        e_le = (kind != 0) && e_asi[3];
        e_fault = 1'b0;
        r_flt = "R10";
        if (kind >= 2 && !priv && e_asi < 8'h80) begin
            if (kind == 2) begin e_fault = 1'b1; r_flt = "R9"; end
            else begin e_fault = PF_FAULT; r_flt = "R11"; end
        end
        if (pair) r_dat = "R8";
        else      r_dat = e_le ? "R6" : "R7";
        @(negedge clk);
        check("R12", "valid", 64'(out_valid), 64'd1);
        check(r_asi, "asi", 64'(out_asi), 64'(e_asi));
        check((kind == 0) ? "R3" : "R5", "little", 64'(out_little), 64'(e_le));
        check(r_dat, "store data", out_st_data, model_swap(sd, sz, pair, e_le));
        check(r_dat, "load data", out_ld_data, model_swap(ld, sz, pair, e_le));
        check(r_flt, "fault", 64'(out_priv_fault), 64'(e_fault));
    endtask

    localparam logic [63:0] PAT_A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] PAT_B = 64'hFEDC_BA98_7654_3210;

    initial begin
        // Reset dominates an active access (R12).
        acc_valid = 1'b1; acc_kind = 2'd2; acc_imm_asi = 8'h10; st_data = PAT_A; ld_raw = PAT_B;
        repeat (3) @(negedge clk);
        check("R12", "reset valid", 64'(out_valid), 64'd0);
        check("R12", "reset asi", 64'(out_asi), 64'd0);
        check("R12", "reset store", out_st_data, 64'd0);
        check("R12", "reset fault", 64'(out_priv_fault), 64'd0);
        rst_n = 1'b1;
        acc_valid = 1'b0;
        @(negedge clk);
        check("R12", "idle valid", 64'(out_valid), 64'd0);

        // Fetch: primary / nucleus, big-endian even with cur_le set (R3).
        do_acc(0, 0, 8'h00, 8'h00, 0, 1, 0, 2, 0, PAT_A, PAT_B);
        do_acc(0, 0, 8'h00, 8'h00, 2, 1, 1, 2, 0, PAT_A, PAT_B);
        // Data: four implicit spaces (R4, R5).
        do_acc(1, 0, 8'h00, 8'h00, 0, 0, 0, 3, 0, PAT_A, PAT_B);
        do_acc(1, 0, 8'h00, 8'h00, 0, 1, 0, 3, 0, PAT_A, PAT_B);
        do_acc(1, 0, 8'h00, 8'h00, 5, 0, 1, 3, 0, PAT_A, PAT_B);
        do_acc(1, 0, 8'h00, 8'h00, 1, 1, 1, 3, 0, PAT_A, PAT_B);
        // Explicit ASI sources (R1, R2).
        do_acc(2, 0, 8'h88, 8'h80, 0, 0, 0, 2, 0, PAT_A, PAT_B);
        do_acc(2, 1, 8'h88, 8'h80, 0, 0, 0, 2, 0, PAT_A, PAT_B);
        // Privilege checks (R9, R10, R11).
        do_acc(2, 0, 8'h10, 8'h80, 0, 0, 0, 1, 0, PAT_A, PAT_B);
        do_acc(2, 0, 8'h10, 8'h80, 0, 0, 1, 1, 0, PAT_A, PAT_B);
        do_acc(2, 1, 8'h00, 8'h81, 0, 0, 0, 1, 0, PAT_A, PAT_B);
        do_acc(2, 1, 8'h00, 8'h7F, 0, 0, 0, 1, 0, PAT_A, PAT_B);
        do_acc(3, 0, 8'h04, 8'h80, 0, 0, 0, 3, 0, PAT_A, PAT_B);
        do_acc(3, 1, 8'h80, 8'h0C, 0, 0, 0, 3, 0, PAT_A, PAT_B);
        // Every size both orders (R6, R7).
        for (int s = 0; s < 4; s++) begin
            do_acc(1, 0, 8'h00, 8'h00, 0, 1, 0, s, 0, PAT_A, PAT_B);
            do_acc(1, 0, 8'h00, 8'h00, 0, 0, 0, s, 0, PAT_A, PAT_B);
        end
        // Pair accesses: size ignored, per-word swap (R8).
        do_acc(1, 0, 8'h00, 8'h00, 0, 1, 0, 0, 1, PAT_A, PAT_B);
        do_acc(2, 0, 8'h0C, 8'h00, 0, 0, 1, 2, 1, PAT_B, PAT_A);
        do_acc(1, 0, 8'h00, 8'h00, 3, 0, 0, 1, 1, PAT_A, PAT_B);
        // Mixed sweep.
        for (int n = 0; n < 400; n++) begin
            logic [7:0] im = 8'($urandom);
            logic [7:0] ar = 8'($urandom);
            do_acc(int'($urandom_range(0, 3)), 1'($urandom), im, ar,
                   int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
                   int'($urandom_range(0, 3)), 1'($urandom),
                   {$urandom, $urandom}, {$urandom, $urandom});
        end
        acc_valid = 1'b0;
        @(negedge clk);
        check("R12", "valid drop", 64'(out_valid), 64'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(200000 * 2 * HALF_NS);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule